// File: doc/BRIEF.md
# Horizontal Readout Timing Generator

This block produces the horizontal timing for the read side of a line-doubling scan converter. A position counter, clocked by the read clock, runs through one display line whose length is the programmed dot count plus two. From that position the block derives a one-clock line reference pulse and a fixed-width horizontal sync. It also produces a read-enable window that opens at a programmable phase, a one-clock horizontal memory clear just ahead of that window, and a horizontal blanking flag with programmable edges.

The blanking flag is an indicator for downstream display logic only. It never masks the read enable, so the two windows may overlap freely. The block has no data path, so every pin is a plain control or status signal with no valid/ready handshake. The four configuration inputs are sampled into a shadow copy only at line boundaries, so a change made in the middle of a line never truncates or stretches it.

Top module: `hrdg_readout_hgen`

## Requirements
- R1: `line_ref_o` is high for exactly one clock, and it recurs every `cfg_line_len + 2` clocks.
- R2: `hsync_o` is high from the line reference for 68 clocks. If the line is shorter than that, it is cut at the line end.
- R3: `rd_en_o` is high from position `cfg_phase + 2` for 1440 clocks, where position 0 is the line reference clock. It is cut at the line end, and it does not appear at all if its start lies beyond the last position.
- R4: `hclr_o` is a single clock at position `cfg_phase + 1`. It is issued only when `rd_en_o` rises within the same line.
- R5: `hblank_o` is high at positions from `cfg_blank_start + 2` up to, but not including, `cfg_blank_end`. It is empty when the end is not past the start. It has no effect on `rd_en_o`.
- R6: A configuration change takes effect only from the next line reference. The current line finishes with its old length and old windows.
- R7: While reset is held, every output is low. The first clock edge after release loads the configuration with all outputs still low. The second edge gives the first line reference. All outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_len | input | 11 | Dot count; the line lasts this plus 2 clocks |
| cfg_phase | input | 11 | Read-enable phase; the window opens at this plus 2 |
| cfg_blank_start | input | 11 | Blanking opens at this plus 2 |
| cfg_blank_end | input | 11 | Blanking closes at this position |
| line_ref_o | output | 1 | One-clock line reference |
| hsync_o | output | 1 | Horizontal sync, 68 clocks |
| rd_en_o | output | 1 | Horizontal read-enable window |
| hclr_o | output | 1 | Horizontal memory clear, one clock before read enable |
| hblank_o | output | 1 | Horizontal blanking indicator |

## Verification
Every output is registered from the counter position. The value for line position r therefore appears after the clock edge that follows the counter reaching r. The first line reference comes on the second edge after reset release, because the first edge only loads the shadow configuration. The bench tracks line position with its own counter from that point and samples each output on the falling clock edge after every rising edge, comparing against the position it expects. New configuration is driven at mid-line, and the remainder of that line is checked against the old values, so the one-line deferral shows at the outputs.

// File: rtl/hrdg_pkg.sv
package hrdg_pkg;
  localparam int CFG_W = 11;

  typedef struct packed {
    logic [CFG_W-1:0] line_len;
    logic [CFG_W-1:0] phase;
    logic [CFG_W-1:0] blank_start;
    logic [CFG_W-1:0] blank_end;
  } hrdg_cfg_t;

  localparam int WIN_SYNC  = 0;
  localparam int WIN_READ  = 1;
  localparam int WIN_BLANK = 2;
  localparam int NUM_WIN   = 3;
endpackage

// File: rtl/hrdg_cfg_shadow.sv
module hrdg_cfg_shadow
  import hrdg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hrdg_cfg_t cfg_i,
  input  logic      load_i,
  output hrdg_cfg_t cfg_o,
  output logic      run_o
);
  hrdg_cfg_t shadow_q;
  logic      run_q;

  // first edge after reset primes the copy; later loads only at line wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      shadow_q <= '0;
    end else if (!run_q) begin
      run_q    <= 1'b1;
      shadow_q <= cfg_i;
    end else if (load_i) begin
      shadow_q <= cfg_i;
    end
  end

  assign cfg_o = shadow_q;
  assign run_o = run_q;

  assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load_i) |=> $stable(shadow_q));
endmodule

// File: rtl/hrdg_line_counter.sv
module hrdg_line_counter #(
  parameter int CFG_W   = 11,
  parameter int LEN_OFS = 2,
  parameter int POS_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CFG_W-1:0] line_len_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] last_pos_o,
  output logic             wrap_o
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last_pos;
  logic             at_last;

  assign last_pos = POS_W'(line_len_i) + POS_W'(LEN_OFS - 1);
  assign at_last  = (pos_q == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos_q <= '0;
    else if (!run_i)     pos_q <= '0;
    else if (at_last)    pos_q <= '0;
    else                 pos_q <= pos_q + 1'b1;
  end

  assign pos_o      = pos_q;
  assign last_pos_o = last_pos;
  assign wrap_o     = run_i && at_last;

  assert_pos_in_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pos_q <= last_pos));
endmodule

// File: rtl/hrdg_window.sv
module hrdg_window #(
  parameter int POS_W = 12,
  parameter int CMP_W = 14
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [CMP_W-1:0] start_i,
  input  logic [CMP_W-1:0] stop_i,
  output logic             hit_o
);
  logic [CMP_W-1:0] pos_ext;
  assign pos_ext = CMP_W'(pos_i);
  assign hit_o   = (pos_ext >= start_i) && (pos_ext < stop_i);
endmodule

// File: rtl/hrdg_readout_hgen.sv
module hrdg_readout_hgen
  import hrdg_pkg::*;
#(
  parameter int SYNC_W   = 68,
  parameter int ACTIVE_W = 1440,
  parameter int LEN_OFS  = 2,
  parameter int EN_OFS   = 2,
  parameter int BLK_OFS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_line_len,
  input  logic [CFG_W-1:0] cfg_phase,
  input  logic [CFG_W-1:0] cfg_blank_start,
  input  logic [CFG_W-1:0] cfg_blank_end,
  output logic             line_ref_o,
  output logic             hsync_o,
  output logic             rd_en_o,
  output logic             hclr_o,
  output logic             hblank_o
);
  localparam int POS_W = $clog2((1 << CFG_W) + LEN_OFS);
  localparam int CMP_W = $clog2((1 << CFG_W) + LEN_OFS + EN_OFS + BLK_OFS + ACTIVE_W + SYNC_W) + 1;

  hrdg_cfg_t        cfg_in, cfg_sh;
  logic             run, wrap;
  logic [POS_W-1:0] pos, last_pos;
  logic [CMP_W-1:0] win_start [NUM_WIN];
  logic [CMP_W-1:0] win_stop  [NUM_WIN];
  logic             win_hit   [NUM_WIN];
  logic [CMP_W-1:0] en_start, last_ext, pos_ext;
  logic             clr_hit;

  assign cfg_in = '{line_len: cfg_line_len, phase: cfg_phase,
                    blank_start: cfg_blank_start, blank_end: cfg_blank_end};

  hrdg_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_in), .load_i(wrap),
    .cfg_o(cfg_sh), .run_o(run)
  );

  hrdg_line_counter #(.CFG_W(CFG_W), .LEN_OFS(LEN_OFS), .POS_W(POS_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run_i(run), .line_len_i(cfg_sh.line_len),
    .pos_o(pos), .last_pos_o(last_pos), .wrap_o(wrap)
  );

  assign en_start = CMP_W'(cfg_sh.phase) + CMP_W'(EN_OFS);
  assign last_ext = CMP_W'(last_pos);
  assign pos_ext  = CMP_W'(pos);

  always_comb begin
    win_start[WIN_SYNC]  = '0;
    win_stop[WIN_SYNC]   = CMP_W'(SYNC_W);
    win_start[WIN_READ]  = en_start;
    win_stop[WIN_READ]   = en_start + CMP_W'(ACTIVE_W);
    win_start[WIN_BLANK] = CMP_W'(cfg_sh.blank_start) + CMP_W'(BLK_OFS);
    win_stop[WIN_BLANK]  = CMP_W'(cfg_sh.blank_end);
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    hrdg_window #(.POS_W(POS_W), .CMP_W(CMP_W)) u_win (
      .pos_i(pos), .start_i(win_start[g]), .stop_i(win_stop[g]), .hit_o(win_hit[g])
    );
  end

  // clear only when the enable actually opens inside this line
  assign clr_hit = (pos_ext + CMP_W'(1) == en_start) && (en_start <= last_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ref_o <= 1'b0;
      hsync_o    <= 1'b0;
      rd_en_o    <= 1'b0;
      hclr_o     <= 1'b0;
      hblank_o   <= 1'b0;
    end else if (!run) begin
      line_ref_o <= 1'b0;
      hsync_o    <= 1'b0;
      rd_en_o    <= 1'b0;
      hclr_o     <= 1'b0;
      hblank_o   <= 1'b0;
    end else begin
      line_ref_o <= (pos == '0);
      hsync_o    <= win_hit[WIN_SYNC];
      rd_en_o    <= win_hit[WIN_READ];
      hclr_o     <= clr_hit;
      hblank_o   <= win_hit[WIN_BLANK];
    end
  end

  assert_ref_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_ref_o |=> !line_ref_o);
  assert_sync_from_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_o) |-> line_ref_o);
  assert_clr_then_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hclr_o |=> $rose(rd_en_o));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(line_ref_o || hsync_o || rd_en_o || hclr_o || hblank_o));
endmodule

// File: tb/hrdg_readout_hgen_bench.sv
`timescale 1ns/1ps
module hrdg_readout_hgen_bench;
  localparam int SYNC = 68;
  localparam int ACT  = 1440;
  localparam int NV   = 7;
  // {line_len, phase, blank_start, blank_end}
  localparam logic [43:0] VEC [NV] = '{
    {11'd908,  11'd100, 11'd20,   11'd880},
    {11'd300,  11'd250, 11'd10,   11'd200},
    {11'd100,  11'd200, 11'd0,    11'd50},
    {11'd40,   11'd5,   11'd30,   11'd10},
    {11'd2047, 11'd0,   11'd1000, 11'd2047},
    {11'd0,    11'd0,   11'd0,    11'd2},
    {11'd100,  11'd97,  11'd60,   11'd90}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] len_i, ph_i, bs_i, be_i;
  logic line_ref_o, hsync_o, rd_en_o, hclr_o, hblank_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hrdg_readout_hgen u_hrdg_readout_hgen (
    .clk(clk), .rst_n(rst_n), .cfg_line_len(len_i), .cfg_phase(ph_i),
    .cfg_blank_start(bs_i), .cfg_blank_end(be_i),
    .line_ref_o(line_ref_o), .hsync_o(hsync_o), .rd_en_o(rd_en_o),
    .hclr_o(hclr_o), .hblank_o(hblank_o)
  );

  task automatic drive(input logic [43:0] c);
    {len_i, ph_i, bs_i, be_i} = c;
  endtask

  function automatic logic [4:0] expv(int r, logic [43:0] c);
    int p, ph, bs, be;
    logic lr, hs, rd, cl, bk;
    p  = int'(c[43:33]) + 2;
    ph = int'(c[32:22]);
    bs = int'(c[21:11]);
    be = int'(c[10:0]);
    lr = (r == 0);
    hs = (r < SYNC);
    rd = (r >= ph + 2) && (r < ph + 2 + ACT);
    cl = (r == ph + 1) && (ph + 2 <= p - 1);
    bk = (r >= bs + 2) && (r < be);
    return {lr, hs, rd, cl, bk};
  endfunction

  task automatic chk(logic got, logic exp, string tag, string sig, int r);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s pos %0d: got %0b expected %0b", tag, sig, r, got, exp);
    end
  endtask

  task automatic chk_idle(string tag);
    chk(line_ref_o, 1'b0, tag, "line_ref", -1);
    chk(hsync_o,    1'b0, tag, "hsync",    -1);
    chk(rd_en_o,    1'b0, tag, "rd_en",    -1);
    chk(hclr_o,     1'b0, tag, "hclr",     -1);
    chk(hblank_o,   1'b0, tag, "hblank",   -1);
  endtask

  // check one full line; drive the next config at mid-line (R6 deferral)
  task automatic run_line(logic [43:0] cur, logic [43:0] nxt);
    int p, dp;
    logic [4:0] e;
    p  = int'(cur[43:33]) + 2;
    dp = (p > 2) ? p / 2 : 0;
    for (int r = 0; r < p; r++) begin
      @(negedge clk);
      e = expv(r, cur);
      chk(line_ref_o, e[4], (r > dp) ? "R6" : "R1", "line_ref", r);
      chk(hsync_o,    e[3], (r > dp) ? "R6" : "R2", "hsync",    r);
      chk(rd_en_o,    e[2], (r > dp) ? "R6" : "R3", "rd_en",    r);
      chk(hclr_o,     e[1], (r > dp) ? "R6" : "R4", "hclr",     r);
      chk(hblank_o,   e[0], (r > dp) ? "R6" : "R5", "hblank",   r);
      if (r == dp) drive(nxt);
    end
  endtask

  initial begin
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    chk_idle("R7");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R7");                 // priming edge: outputs still low
    for (int v = 0; v < NV; v++)
      run_line(VEC[v], (v < NV - 1) ? VEC[v + 1] : VEC[v]);
    // directed: reset in mid-line, new config during reset
    run_line(VEC[6], VEC[6]);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    drive(VEC[1]);
    #1;
    chk_idle("R7");
    repeat (2) @(negedge clk);
    chk_idle("R7");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R7");
    run_line(VEC[1], VEC[3]);
    run_line(VEC[3], VEC[3]);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule